// File: doc/BRIEF.md
# Host Register and Memory Slave

This block is a word-addressed slave on a simple 16-bit host bus. Every address names one 16-bit word. The map has four regions.

- **Identification word.** A fixed word, read-only.
- **Lock register.** Its bits start at one after reset. A bit is knocked down by writing a one to it.
- **Register file.** A bank of general read/write registers.
- **RAM window.** A single-port memory.

A host raises `req` for one cycle, with the direction, the address and any write data. Writes land on the clock edge that samples the request. Read data comes back on the following cycle with a one-cycle valid pulse.

Any request that falls outside the four regions is not acted on. It is reported with an error pulse one cycle later.

Top module: `host_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, the registers return to their reset values: lock word 0xFFFF, and every register-file entry 0x0000. In the cycle after reset, `rvalid` and `err` are low. RAM contents are not reset.
- R2: A read of address 0x0000 returns 0x5A03. The revision value 0x03 is in bits 7:0 and the chip value 0x5A is in bits 15:8.
- R3: A write to address 0x0000 has no effect; later reads still return 0x5A03.
- R4: The lock word at 0x0100 is write-one-to-clear. Each write data bit at 1 clears that lock bit, and each bit at 0 leaves it unchanged. No bit ever returns to 1 except through reset.
- R5: Addresses 0x1000 + i, for i from 0 to 255, hold 256 read/write registers. Register i is at offset i.
- R6: Addresses 0x4000 + i, for i from 0 to 4095, hold a 4096 x 16 read/write RAM. Word i is at offset i.
- R7: A read of any other address returns 0x0000 with `err` high. A write to any other address changes no state and also raises `err`.
- R8: For a read sampled at edge N, `rdata` is valid after edge N+1, and `rvalid` is high for exactly that one cycle. A write sampled at edge N is visible to a read issued in the next cycle.
- R9: `err` stays low for requests to mapped addresses. `rvalid` stays low after a write request and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid together with `rvalid` |
| rvalid | output | 1 | One-cycle pulse one clock after a read request |
| err | output | 1 | One-cycle pulse one clock after a request to an unmapped address |

## Verification
The assertions check several properties on every cycle:
- the lock word never gains a set bit outside reset;
- the response pulses only follow a request of the matching kind;
- every identification read returns the fixed word;
- every error read returns zero.

What lands in the register file and the RAM at each offset can only be shown by the bench. It writes a Gray-code pattern to the register file and a walking-one pattern to the RAM, then reads all of them back. A seeded random mix of reads, writes and unmapped addresses is then checked against a bench model. That mix shows that writes to the identification word and to unmapped addresses leave every readable location unchanged.

// File: rtl/host_regfile.sv
module host_regfile #(
  parameter int DW         = 16,
  parameter int AW         = 16,
  parameter int NREG       = 256,
  parameter int RAM_DEPTH  = 4096,
  parameter logic [AW-1:0] ID_ADDR   = 16'h0000,
  parameter logic [AW-1:0] LOCK_ADDR = 16'h0100,
  parameter logic [AW-1:0] REG_BASE  = 16'h1000,
  parameter logic [AW-1:0] RAM_BASE  = 16'h4000,
  parameter logic [DW/2-1:0] REV_VAL  = 8'h03,
  parameter logic [DW/2-1:0] CHIP_VAL = 8'h5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          err
);
  localparam int REG_AW = $clog2(NREG);
  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam logic [DW-1:0] ID_WORD = {CHIP_VAL, REV_VAL};

  logic [DW-1:0] lock_q;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] ram  [RAM_DEPTH];

  wire hit_id   = addr == ID_ADDR;
  wire hit_lock = addr == LOCK_ADDR;
  wire hit_reg  = addr[AW-1:REG_AW] == REG_BASE[AW-1:REG_AW];
  wire hit_ram  = addr[AW-1:RAM_AW] == RAM_BASE[AW-1:RAM_AW];
  wire hit_any  = hit_id | hit_lock | hit_reg | hit_ram;
  wire wr       = req & we;
  wire rd       = req & ~we;

  wire [REG_AW-1:0] reg_idx = addr[REG_AW-1:0];
  wire [RAM_AW-1:0] ram_idx = addr[RAM_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '1;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr) begin
      if (hit_lock) lock_q <= lock_q & ~wdata;
      if (hit_reg)  regs[reg_idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && hit_ram) ram[ram_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= rd;
      err    <= req & ~hit_any;
      if (rd) begin
        if (hit_id)        rdata <= ID_WORD;
        else if (hit_lock) rdata <= lock_q;
        else if (hit_reg)  rdata <= regs[reg_idx];
        else if (hit_ram)  rdata <= ram[ram_idx];
        else               rdata <= '0;
      end
    end
  end

  assert_id_value_R2: assert property (@(posedge clk) disable iff (rst)
    rvalid && $past(addr) == ID_ADDR |-> rdata == ID_WORD);

  assert_lock_no_set_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lock_q & ~$past(lock_q)) == '0);

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rvalid && err |-> rdata == '0);

  assert_rvalid_cause_R8: assert property (@(posedge clk) disable iff (rst)
    req && !we |=> rvalid);

  assert_rvalid_only_read_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rvalid == $past(req && !we));

  assert_err_only_req_R9: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req));

endmodule

// File: tb/host_regfile_tb.sv
module host_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid;
  logic        err;

  int checks = 0;
  int fails = 0;

  logic [15:0] m_lock;
  logic [15:0] m_reg [256];
  logic [15:0] m_ram [4096];

  always #10 clk = ~clk;

  host_regfile u_dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic mapped(input logic [15:0] a);
    return a == 16'h0000 || a == 16'h0100 || a[15:8] == 8'h10 || a[15:12] == 4'h4;
  endfunction

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    if (a == 16'h0000) return 16'h5A03;
    if (a == 16'h0100) return m_lock;
    if (a[15:8] == 8'h10) return m_reg[a[7:0]];
    if (a[15:12] == 4'h4) return m_ram[a[11:0]];
    return 16'h0000;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [15:0] d);
    if (a == 16'h0100) m_lock = m_lock & ~d;
    else if (a[15:8] == 8'h10) m_reg[a[7:0]] = d;
    else if (a[15:12] == 4'h4) m_ram[a[11:0]] = d;
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output logic v, output logic e);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd = rdata; v = rvalid; e = err;
  endtask

  task automatic do_write(input string tag, input logic [15:0] a, input logic [15:0] d);
    logic [15:0] r; logic v, e;
    access(1'b1, a, d, r, v, e);
    model_write(a, d);
    chk({tag, " write rvalid (R9)"}, v, 0);
    chk({tag, " write err (R7/R9)"}, e, !mapped(a));
  endtask

  task automatic do_read(input string tag, input logic [15:0] a);
    logic [15:0] r; logic v, e;
    access(1'b0, a, 16'h0, r, v, e);
    chk({tag, " rdata"}, r, exp_read(a));
    chk({tag, " rvalid (R8)"}, v, 1);
    chk({tag, " err (R7/R9)"}, e, !mapped(a));
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_lock = 16'hFFFF;
    for (int i = 0; i < 256; i++) m_reg[i] = 16'h0;
    for (int i = 0; i < 4096; i++) m_ram[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rvalid after reset", rvalid, 0);
    chk("R1 err after reset", err, 0);

    do_read("R1 lock reset", 16'h0100);
    do_read("R1 reg0 reset", 16'h1000);
    do_read("R1 reg255 reset", 16'h10FF);
    do_read("R2 id", 16'h0000);

    do_write("R3 id", 16'h0000, 16'h1234);
    do_read("R3 id after write", 16'h0000);

    do_write("R4 lock partial", 16'h0100, 16'h00F0);
    do_read("R4 lock partial", 16'h0100);
    do_write("R4 lock zeros", 16'h0100, 16'h0000);
    do_read("R4 lock zeros", 16'h0100);
    do_write("R4 lock all", 16'h0100, 16'hFFFF);
    do_read("R4 lock all", 16'h0100);
    chk("R4 lock cleared value", exp_read(16'h0100), 0);

    begin
      logic [15:0] r; logic v, e;
      access(1'b0, 16'h0000, 16'h0, r, v, e);
      @(negedge clk);
      chk("R8 rvalid one-cycle pulse", rvalid, 0);
      access(1'b1, 16'h1005, 16'hBEEF, r, v, e);
      m_reg[5] = 16'hBEEF;
      access(1'b0, 16'h1005, 16'h0, r, v, e);
      chk("R8 write visible next read", r, 16'hBEEF);
    end

    for (int i = 0; i < 256; i++) do_write("R5 gray", 16'h1000 + 16'(i), 16'(i ^ (i >> 1)));
    for (int i = 0; i < 256; i++) do_read("R5 gray", 16'h1000 + 16'(i));
    for (int i = 0; i < 4096; i++) do_write("R6 walk", 16'h4000 + 16'(i), 16'(1) << (i % 16));
    for (int i = 0; i < 4096; i++) do_read("R6 walk", 16'h4000 + 16'(i));

    do_read("R7 unmapped 0001", 16'h0001);
    do_read("R7 unmapped 1100", 16'h1100);
    do_read("R7 unmapped 5000", 16'h5000);
    do_read("R7 unmapped FFFF", 16'hFFFF);
    do_write("R7 unmapped 3FFF", 16'h3FFF, 16'hA5A5);
    do_read("R7 reg after unmapped write", 16'h10FF);
    do_read("R7 ram after unmapped write", 16'h4FFF);

    for (int n = 0; n < 800; n++) begin
      logic [15:0] a;
      logic [15:0] d;
      int sel;
      sel = int'($urandom % 5);
      d = 16'($urandom);
      case (sel)
        0: a = 16'h0000;
        1: a = 16'h0100;
        2: a = 16'h1000 | 16'($urandom % 256);
        3: a = 16'h4000 | 16'($urandom % 4096);
        default: begin
          a = 16'($urandom);
          while (mapped(a)) a = 16'($urandom);
        end
      endcase
      if ($urandom % 2) do_write("R3/R4/R5/R6/R7 random", a, d);
      else do_read("R2/R4/R5/R6/R7 random", a);
    end
    for (int i = 0; i < 256; i++) do_read("R7 reg sweep after random", 16'h1000 + 16'(i));
    do_read("R3 id after random", 16'h0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule